// File: doc/BRIEF.md
# Programmable SCL Bit Timer

This block times one bit period of the serial clock for a two-wire bus master. A 5-bit clock-select code and a mode bit (standard or fast) give a divisor `m`. For each requested bit, the block pulls SCL low through an open-drain enable for `m` module clocks and then releases the line. It counts the high phase only once the filtered SCL input has actually been seen high. A slave that stretches the clock, or a slow rising edge, therefore lengthens the bit instead of shortening it. If another master pulls SCL low during the high phase, the block ends its own high phase at once, so the slowest device on the bus sets the timing.

Along the way the block marks three points. It pulses when SDA may change, a fixed hold time after SCL was pulled low. It pulses when SDA should be sampled, which is the first cycle SCL is confirmed high. It pulses when the bit ends. A hold request, driven by a pending interrupt elsewhere, keeps SCL low after the low count is complete. In fast mode, codes below 8 are inhibited: they raise an error output and no clock is produced. START/STOP sequencing and byte shifting belong to neighbouring blocks.

The controller has four states:
- `PH_IDLE`: SCL is released and the block waits for a request. It moves to `PH_LOW` on `bit_req` with a legal code.
- `PH_LOW`: SCL is driven low while the low count runs. At the last count, if `hold_req` is clear, it moves to `PH_WAIT`.
- `PH_WAIT`: SCL is released and the block waits for the line to be seen high. Seeing it high moves it to `PH_HIGH`.
- `PH_HIGH`: SCL is released while the high count runs. It ends at the last count, or at once if the line falls. If a legal `bit_req` is present it goes back to `PH_LOW`; otherwise it goes to `PH_IDLE`.

Top module: `scl_bit_timer`

## Requirements
- R1: After reset `scl_oe`, `busy`, `sda_change`, `sda_sample` and `bit_done` are all 0.
- R2: In standard mode (`fast_mode`=0) the divisor is m = code + 65, and `scl_oe` stays asserted for exactly m consecutive cycles when `hold_req` is 0.
- R3: In fast mode (`fast_mode`=1) with codes 8 to 31 the divisor is m = code + 1, and the low phase lasts exactly m cycles.
- R4: The high phase is counted from the clock edge at which `scl_in` is first sampled high after release. From that edge SCL stays released for H further cycles, where H = m+1 in standard mode and floor(m/2)+1 in fast mode. With a line that rises at once, the rising edges of `scl_oe` in back-to-back bits are 2m+2 (standard) or m+floor(m/2)+2 (fast) cycles apart.
- R5: While `scl_in` stays low after release, the block keeps `busy`=1 and `scl_oe`=0, gives no `sda_sample` and does not count the high phase.
- R6: If `scl_in` is low during the high phase, `bit_done` is 1 in that cycle. If `bit_req` is 1, `scl_oe` is asserted in the next cycle.
- R7: `sda_change` is a one-cycle pulse in the fifth cycle of each low phase, 4 cycles after `scl_oe` rises.
- R8: `sda_sample` is a one-cycle pulse in the first cycle of the high phase. With a line that rises at once, this is 1 cycle after `scl_oe` falls.
- R9: `bit_done` pulses in the last high-phase cycle. The next bit starts in the next cycle if `bit_req` is 1; otherwise the block returns to idle (`busy`=0).
- R10: If `hold_req` is 1 when the low count completes, `scl_oe` stays asserted until the first clock edge at which `hold_req` is sampled 0.
- R11: In fast mode, codes 0 to 7 set `cfg_err`=1 combinationally. A `bit_req` under such a code is ignored: `scl_oe` and `busy` stay 0.
- R12: `fast_mode` and `clk_sel` are sampled when a bit starts. Changing them during a bit does not change that bit's timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fast_mode | input | 1 | 0 = standard divisor map, 1 = fast divisor map |
| clk_sel | input | 5 | Clock-select code |
| bit_req | input | 1 | Request to clock one bit; held for back-to-back bits |
| hold_req | input | 1 | Keeps SCL low after the low count completes |
| scl_in | input | 1 | Filtered level of the SCL line |
| scl_oe | output | 1 | 1 = pull SCL low |
| sda_change | output | 1 | Pulse: SDA may change now |
| sda_sample | output | 1 | Pulse: sample SDA now |
| bit_done | output | 1 | Pulse: last cycle of the bit |
| busy | output | 1 | A bit is in progress |
| cfg_err | output | 1 | Selected fast-mode code is inhibited |

## Verification
The bench targets the ends of both divisor maps and the odd/even halving of fast-mode divisors. A design that got these wrong would produce a period off by one cycle. It also holds SCL low from outside after release: a design that counted the high phase from the release instead would sample SDA while the line is still low. It pulls SCL low in mid-high phase, where a design without synchronisation would keep counting and drift from the other master. Further tests cover a hold request, a configuration change during a bit and an inhibited fast code. Each of these would show up as a stretched or truncated low phase, or as a clock produced where none may run.

// File: rtl/scl_timer_pkg.sv
package scl_timer_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_LOW  = 2'd1,
        PH_WAIT = 2'd2,
        PH_HIGH = 2'd3
    } scl_phase_e;

endpackage

// File: rtl/scl_div_decode.sv
module scl_div_decode #(
    parameter int CODE_W    = 5,
    parameter int CNT_W     = 7,
    parameter int STD_BASE  = 65,
    parameter int FAST_BASE = 1,
    parameter int FAST_MIN  = 8
) (
    input  logic [CODE_W-1:0] code,
    input  logic              fast,
    output logic [CNT_W-1:0]  low_len,
    output logic [CNT_W-1:0]  high_len,
    output logic              inhibit
);

    localparam logic [CNT_W-1:0]  STD_B  = CNT_W'(STD_BASE);
    localparam logic [CNT_W-1:0]  FAST_B = CNT_W'(FAST_BASE);
    localparam logic [CNT_W-1:0]  ONE    = CNT_W'(1);
    localparam logic [CODE_W-1:0] MIN_C  = CODE_W'(FAST_MIN);

    logic [CNT_W-1:0] code_w;
    assign code_w = CNT_W'(code);

    // Low phase = m; high phase counted after the line is seen high.
    always_comb begin
        if (fast) begin
            low_len  = code_w + FAST_B;
            high_len = (low_len >> 1) + ONE;
        end else begin
            low_len  = code_w + STD_B;
            high_len = low_len + ONE;
        end
    end

    assign inhibit = fast && (code < MIN_C);

endmodule

// File: rtl/scl_phase_counter.sv
module scl_phase_counter #(
    parameter int CNT_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             en,
    output logic [CNT_W-1:0] cnt
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (en) begin
            cnt <= cnt + CNT_W'(1);
        end
    end

    // R2: an enabled count advances by exactly one
    p_count_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && en) |=> (cnt == $past(cnt) + CNT_W'(1)));

    // R10: a frozen count (held low phase) does not move
    p_count_freeze_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !en) |=> $stable(cnt));

endmodule

// File: rtl/scl_phase_fsm.sv
module scl_phase_fsm
    import scl_timer_pkg::*;
#(
    parameter int CNT_W    = 7,
    parameter int SDA_HOLD = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_req,
    input  logic             hold_req,
    input  logic             scl_in,
    input  logic             inhibit,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] low_lim,
    input  logic [CNT_W-1:0] high_lim,
    output logic             cnt_clr,
    output logic             cnt_en,
    output logic             load_cfg,
    output logic             scl_oe,
    output logic             busy,
    output logic             sda_change,
    output logic             sda_sample,
    output logic             bit_done
);

    localparam logic [CNT_W-1:0] HOLD_IDX = CNT_W'(SDA_HOLD - 1);
    localparam logic [CNT_W-1:0] ONE      = CNT_W'(1);

    scl_phase_e state_q, state_d;

    logic low_last, high_last, high_end, restart;

    assign low_last  = (cnt == low_lim - ONE);
    assign high_last = (cnt == high_lim - ONE);
    assign high_end  = high_last || !scl_in;
    assign restart   = bit_req && !inhibit;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PH_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d  = state_q;
        cnt_clr  = 1'b0;
        cnt_en   = 1'b0;
        load_cfg = 1'b0;
        unique case (state_q)
            PH_IDLE: begin
                if (restart) begin
                    state_d  = PH_LOW;
                    cnt_clr  = 1'b1;
                    load_cfg = 1'b1;
                end
            end
            PH_LOW: begin
                if (low_last) begin
                    if (!hold_req) begin
                        state_d = PH_WAIT;
                    end
                end else begin
                    cnt_en = 1'b1;
                end
            end
            PH_WAIT: begin
                if (scl_in) begin
                    state_d = PH_HIGH;
                    cnt_clr = 1'b1;
                end
            end
            PH_HIGH: begin
                if (high_end) begin
                    if (restart) begin
                        state_d  = PH_LOW;
                        cnt_clr  = 1'b1;
                        load_cfg = 1'b1;
                    end else begin
                        state_d = PH_IDLE;
                    end
                end else begin
                    cnt_en = 1'b1;
                end
            end
            default: state_d = PH_IDLE;
        endcase
    end

    always_comb begin
        scl_oe     = 1'b0;
        busy       = 1'b1;
        sda_change = 1'b0;
        sda_sample = 1'b0;
        bit_done   = 1'b0;
        unique case (state_q)
            PH_IDLE: busy = 1'b0;
            PH_LOW: begin
                scl_oe     = 1'b1;
                sda_change = (cnt == HOLD_IDX);
            end
            PH_WAIT: begin
                scl_oe = 1'b0;
            end
            PH_HIGH: begin
                sda_sample = (cnt == '0);
                bit_done   = high_end;
            end
            default: busy = 1'b0;
        endcase
    end

    // R11: an inhibited code never starts a bit
    p_inhibit_blocks_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PH_IDLE && inhibit) |=> (state_q == PH_IDLE));

    // R5: a low line after release keeps the block waiting
    p_stretch_wait_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PH_WAIT && !scl_in) |=> (state_q == PH_WAIT && !scl_oe));

    // R10: hold request keeps SCL pulled low
    p_hold_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PH_LOW && hold_req) |=> scl_oe);

    // R6: another master pulling SCL low ends the high phase
    p_sync_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PH_HIGH && !scl_in) |=> (state_q != PH_HIGH));

    // R7: the change point lies inside the low phase
    p_change_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
        sda_change |-> scl_oe);

    // R8: sampling only while the line is high
    p_sample_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
        sda_sample |-> scl_in);

    // R9: the three event pulses never coincide
    p_pulses_apart_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({sda_change, sda_sample, bit_done}));

endmodule

// File: rtl/scl_bit_timer.sv
module scl_bit_timer #(
    parameter int CODE_W    = 5,
    parameter int STD_BASE  = 65,
    parameter int FAST_BASE = 1,
    parameter int FAST_MIN  = 8,
    parameter int SDA_HOLD  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fast_mode,
    input  logic [CODE_W-1:0] clk_sel,
    input  logic              bit_req,
    input  logic              hold_req,
    input  logic              scl_in,
    output logic              scl_oe,
    output logic              sda_change,
    output logic              sda_sample,
    output logic              bit_done,
    output logic              busy,
    output logic              cfg_err
);

    localparam int CNT_W = $clog2(STD_BASE + (1 << CODE_W) + 2);

    logic [CNT_W-1:0] low_len, high_len;
    logic [CNT_W-1:0] low_q, high_q;
    logic [CNT_W-1:0] cnt;
    logic             inhibit, cnt_clr, cnt_en, load_cfg;

    scl_div_decode #(
        .CODE_W   (CODE_W),
        .CNT_W    (CNT_W),
        .STD_BASE (STD_BASE),
        .FAST_BASE(FAST_BASE),
        .FAST_MIN (FAST_MIN)
    ) u_decode (
        .code    (clk_sel),
        .fast    (fast_mode),
        .low_len (low_len),
        .high_len(high_len),
        .inhibit (inhibit)
    );

    // Timing captured once per bit; later changes wait for the next bit.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            low_q  <= '0;
            high_q <= '0;
        end else if (load_cfg) begin
            low_q  <= low_len;
            high_q <= high_len;
        end
    end

    scl_phase_counter #(
        .CNT_W(CNT_W)
    ) u_count (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (cnt_clr),
        .en   (cnt_en),
        .cnt  (cnt)
    );

    scl_phase_fsm #(
        .CNT_W   (CNT_W),
        .SDA_HOLD(SDA_HOLD)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_req   (bit_req),
        .hold_req  (hold_req),
        .scl_in    (scl_in),
        .inhibit   (inhibit),
        .cnt       (cnt),
        .low_lim   (low_q),
        .high_lim  (high_q),
        .cnt_clr   (cnt_clr),
        .cnt_en    (cnt_en),
        .load_cfg  (load_cfg),
        .scl_oe    (scl_oe),
        .busy      (busy),
        .sda_change(sda_change),
        .sda_sample(sda_sample),
        .bit_done  (bit_done)
    );

    assign cfg_err = inhibit;

    // R12: captured timing does not move while a bit runs
    p_cfg_frozen_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !load_cfg) |=> $stable(low_q));

endmodule

// File: tb/scl_bit_timer_tb_top.sv
module scl_bit_timer_tb_top;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic       rst_n, fast_mode, bit_req, hold_req, ext_low;
    logic [4:0] clk_sel;
    logic       scl_in, scl_oe, sda_change, sda_sample, bit_done, busy, cfg_err;

    // Wired-AND line: low if this block or anyone else pulls it.
    assign scl_in = !(scl_oe || ext_low);

    scl_bit_timer dut_i (
        .clk(clk), .rst_n(rst_n), .fast_mode(fast_mode), .clk_sel(clk_sel),
        .bit_req(bit_req), .hold_req(hold_req), .scl_in(scl_in),
        .scl_oe(scl_oe), .sda_change(sda_change), .sda_sample(sda_sample),
        .bit_done(bit_done), .busy(busy), .cfg_err(cfg_err)
    );

    int n_cmp = 0, n_bad = 0, cyc = 0;
    bit finished = 0;
    // reference model state
    int mph = 0, el = 0, mm = 0, hh = 0;
    // monitor
    int rise_cyc = 0, fall_cyc = 0, low_len = -1, period = -1;
    int chg_dist = -1, smp_dist = -1, smp_count = 0;
    bit have_rise = 0, prev_oe = 0;

    function automatic int f_m(input bit f, input int c);
        return f ? c + 1 : c + 65;
    endfunction
    function automatic int f_h(input bit f, input int c);
        return f ? f_m(f, c) / 2 + 1 : f_m(f, c) + 1;
    endfunction
    function automatic bit f_inh(input bit f, input int c);
        return f && (c < 8);
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    // Reference compare and advance, once per cycle, away from the edge.
    always @(negedge clk) begin
        #2;
        if (!rst_n) begin
            mph = 0; el = 0;
        end else if (!finished) begin
            bit e_oe, e_busy, e_err, e_chg, e_smp, e_done;
            e_oe   = (mph == 1);
            e_busy = (mph != 0);
            e_err  = f_inh(fast_mode, int'(clk_sel));
            e_chg  = (mph == 1) && (el == 4);
            e_smp  = (mph == 3) && (el == 0);
            e_done = (mph == 3) && ((el == hh - 1) || !scl_in);
            chk(scl_oe == e_oe,         "R2/R3 scl_oe",   scl_oe,     e_oe);
            chk(busy == e_busy,         "R9 busy",        busy,       e_busy);
            chk(cfg_err == e_err,       "R11 cfg_err",    cfg_err,    e_err);
            chk(sda_change == e_chg,    "R7 sda_change",  sda_change, e_chg);
            chk(sda_sample == e_smp,    "R8 sda_sample",  sda_sample, e_smp);
            chk(bit_done == e_done,     "R9 bit_done",    bit_done,   e_done);
            // monitor
            cyc++;
            if (scl_oe && !prev_oe) begin
                if (have_rise) period = cyc - rise_cyc;
                rise_cyc = cyc; have_rise = 1;
            end
            if (!scl_oe && prev_oe) begin
                low_len = cyc - rise_cyc; fall_cyc = cyc;
            end
            if (sda_change) chg_dist = cyc - rise_cyc;
            if (sda_sample) begin smp_dist = cyc - fall_cyc; smp_count++; end
            prev_oe = scl_oe;
            // advance model with inputs that the next edge will see
            case (mph)
                0: if (bit_req && !f_inh(fast_mode, int'(clk_sel))) begin
                       mm = f_m(fast_mode, int'(clk_sel)); hh = f_h(fast_mode, int'(clk_sel));
                       mph = 1; el = 0;
                   end
                1: if (el >= mm - 1) begin
                       if (!hold_req) mph = 2;
                   end else el++;
                2: if (scl_in) begin mph = 3; el = 0; end
                default: if ((el == hh - 1) || !scl_in) begin
                       if (bit_req && !f_inh(fast_mode, int'(clk_sel))) begin
                           mm = f_m(fast_mode, int'(clk_sel)); hh = f_h(fast_mode, int'(clk_sel));
                           mph = 1; el = 0;
                       end else mph = 0;
                   end else el++;
            endcase
        end
    end

    task automatic train(input bit f, input int c, input string req);
        int m, p;
        m = f_m(f, c);
        p = f ? m + m / 2 + 2 : 2 * m + 2;
        @(negedge clk);
        fast_mode = f; clk_sel = 5'(c); have_rise = 0; bit_req = 1;
        repeat (3 * p + 5) @(negedge clk);
        bit_req = 0;
        repeat (p + 5) @(negedge clk);
        #3;
        chk(low_len == m,  {req, " low phase"},  low_len, m);
        chk(period == p,   "R4 bit period",      period,  p);
        chk(chg_dist == 4, "R7 change point",    chg_dist, 4);
        chk(smp_dist == 1, "R8 sample point",    smp_dist, 1);
        chk(busy == 0,     "R9 back to idle",    busy,    0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog expired actual=1 expected=0");
            finish_run();
        end
    end

    initial begin
        rst_n = 0; fast_mode = 0; clk_sel = 0; bit_req = 0; hold_req = 0; ext_low = 0;
        repeat (3) @(negedge clk);
        #3;
        chk(scl_oe == 0 && busy == 0 && bit_done == 0 && sda_change == 0 && sda_sample == 0,
            "R1 reset state", {scl_oe, busy, bit_done}, 0);
        @(negedge clk);
        rst_n = 1;
        repeat (2) @(negedge clk);

        train(0, 0,  "R2");
        train(0, 31, "R2");
        train(1, 8,  "R3");
        train(1, 12, "R3");
        train(1, 31, "R3");

        // R11: inhibited fast code
        @(negedge clk);
        fast_mode = 1; clk_sel = 5'd3;
        #3 chk(cfg_err == 1, "R11 cfg_err raised", cfg_err, 1);
        @(negedge clk);
        bit_req = 1;
        repeat (10) @(negedge clk);
        #3 chk(scl_oe == 0 && busy == 0, "R11 request ignored", {scl_oe, busy}, 0);
        @(negedge clk);
        bit_req = 0; clk_sel = 5'd8;

        // R5: stretching after release
        @(negedge clk);
        smp_count = 0; bit_req = 1; ext_low = 1;
        @(negedge clk);
        bit_req = 0;
        repeat (28) @(negedge clk);
        #3 chk(busy == 1 && scl_oe == 0 && smp_count == 0, "R5 waits for line",
               {busy, scl_oe, 4'(smp_count)}, 6'b100000);
        @(negedge clk);
        ext_low = 0;
        repeat (15) @(negedge clk);
        #3 chk(smp_count == 1 && busy == 0, "R5 resumes after rise", smp_count, 1);

        // R6: another master pulls SCL low during the high phase
        @(negedge clk);
        clk_sel = 5'd31; bit_req = 1;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            #3;
            if (sda_sample) break;
        end
        repeat (3) @(negedge clk);
        ext_low = 1;
        #3 chk(bit_done == 1, "R6 early end of high phase", bit_done, 1);
        @(negedge clk);
        #3 chk(scl_oe == 1, "R6 next low phase follows", scl_oe, 1);
        @(negedge clk);
        ext_low = 0; bit_req = 0;
        repeat (120) @(negedge clk);

        // R10: hold request keeps SCL low
        @(negedge clk);
        clk_sel = 5'd8; hold_req = 1; bit_req = 1;
        @(negedge clk);
        bit_req = 0;
        repeat (30) @(negedge clk);
        #3 chk(scl_oe == 1, "R10 held low", scl_oe, 1);
        @(negedge clk);
        hold_req = 0;
        #3 chk(scl_oe == 1, "R10 still low before edge", scl_oe, 1);
        @(negedge clk);
        #3 chk(scl_oe == 0, "R10 released after hold drop", scl_oe, 0);
        repeat (20) @(negedge clk);

        // R12: configuration change during a bit
        @(negedge clk);
        have_rise = 0; fast_mode = 1; clk_sel = 5'd8; bit_req = 1;
        @(negedge clk);
        bit_req = 0;
        @(negedge clk);
        fast_mode = 0; clk_sel = 5'd31;
        repeat (30) @(negedge clk);
        #3;
        chk(low_len == 9, "R12 low phase kept", low_len, 9);
        chk(busy == 0,    "R12 bit kept its length", busy, 0);

        repeat (5) @(negedge clk);
        finish_run();
    end

endmodule